// File: doc/BRIEF.md
# Logical Mesh Mapping Scorer

This block rates how well a set of cores, picked out of a physical mesh that contains spare cores, stands in for a smaller logical mesh. A mapping table, held outside the block, tells for each logical node which physical core (row, column) carries it. After a start pulse the block reads the table through a one-address read port. It visits every logical node and each of its logical neighbours, and walks the physical route between the two cores. From this walk it builds three scores: a mean hop-distance score, a link-congestion score and a weighted sum of the two.

The congestion score is the standard deviation of per-link usage counts. These counts are gathered by routing every directed logical-neighbour pair along a dimension-order path: first along the columns until the columns match, then along the rows. All results and weights are unsigned fixed-point values with 8 fractional bits. A search engine or a boot-time repair controller would call the block once per candidate mapping and keep the mapping with the lowest weighted score.

Top module: `lt_topo_eval`

## Requirements
- R1: While reset is held and after it is released, `busy` and `done` are low and `df_q`, `cf_q` and `um_q` are zero.
- R2: A `start` sampled high while idle raises `busy` in the next cycle. `busy` stays high until the cycle in which `done` pulses high for exactly one cycle, and `busy` is low in that cycle.
- R3: A `start` sampled while `busy` is high is ignored. The weights used are the ones sampled with the accepted `start`.
- R4: `map_addr` carries a logical index `i*COLS + j` within 0..N-1. The physical row and column for that index are returned on `map_prow`/`map_pcol` in the same cycle.
- R5: For node n with k_n logical neighbours (up, down, right, left, whichever exist) and hop sum h_n, `df_q` = floor(sum over n of floor(256*h_n/k_n) / N). The hop count between two cores is |row difference| + |column difference|.
- R6: A mapping that places every logical node on the physical core with the same row and column gives `df_q` = 256 (1.0).
- R7: Each logical-neighbour pair is routed in both directions. Each route first steps along the column direction until the columns are equal, then along the row direction. Every physical link it crosses gains one count.
- R8: With L physical links, S the sum of the link counts and Q the sum of their squares, `cf_q` = floor(sqrt(floor(65536*(L*Q - S*S) / (L*L)))).
- R9: When the physical mesh has the same size as the logical mesh and the mapping is the identity, `cf_q` = 0.
- R10: `um_q` = floor((w_df*df_q + w_cf*cf_q) / 256). The weights are 9-bit Q8 values (256 means 1.0).
- R11: Every link count is cleared when a run starts, so a repeated run on the same mapping gives identical results.
- R12: `df_q`, `cf_q` and `um_q` change only in the cycle in which `done` is high, and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an evaluation when idle |
| w_df | input | WGT_W | Distance weight, Q8 |
| w_cf | input | WGT_W | Congestion weight, Q8 |
| map_addr | output | NI_W | Logical node index being read |
| map_prow | input | PR_W | Physical row of the addressed node |
| map_pcol | input | PC_W | Physical column of the addressed node |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle completion pulse |
| df_q | output | RES_W | Distance factor, Q8 |
| cf_q | output | RES_W | Congestion factor, Q8 |
| um_q | output | RES_W | Weighted score, Q8 |

## Verification
The bench uses several kinds of mapping: an identity mapping on a mesh with a spare column, a row shifted around a bad core, and scrambled mappings with cores taken from other rows. A design that routed rows first, counted each pair only once, or used a wrong floor in the per-node average would give a different distance or congestion value for at least one of them. An identity mapping on a mesh with no spares must score zero congestion; a design that kept stale counts or miscounted links would show a nonzero spread there or on a repeated run. A second start during a run, with other weights, must leave the first run's weighting and timing untouched. A design that restarted or resampled the weights would produce a late pulse or a weighted score that does not equal the distance score.

// File: rtl/lt_eval_pkg.sv
package lt_eval_pkg;

   // index width for a range of v values (at least one bit)
   function automatic int lt_bits(input int v);
      return (v <= 2) ? 1 : $clog2(v);
   endfunction

   typedef enum logic [3:0] {
      S_IDLE,
      S_SELF,
      S_DIR,
      S_ROUTE,
      S_NDIV,
      S_NWAIT,
      S_SCAN,
      S_VDIV,
      S_VWAIT,
      S_ROOT,
      S_RWAIT,
      S_DDIV,
      S_DWAIT
   } eval_state_t;

endpackage

// File: rtl/lt_link_bank.sv
module lt_link_bank #(
   parameter int NUM   = 17,
   parameter int CNT_W = 8,
   parameter int IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   input  logic [IDX_W-1:0] inc_idx,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [CNT_W-1:0] rd_cnt
);

   logic [CNT_W-1:0] cnt_arr [NUM];

   generate
      for (genvar g = 0; g < NUM; g++) begin : g_cnt
         logic [CNT_W-1:0] c_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               c_q <= '0;
            end else if (clr) begin
               c_q <= '0;
            end else if (inc && (inc_idx == IDX_W'(g)) && (c_q != '1)) begin
               c_q <= c_q + 1'b1;
            end
         end
         assign cnt_arr[g] = c_q;
      end
   endgenerate

   assign rd_cnt = cnt_arr[rd_idx];

endmodule

// File: rtl/lt_seq_div.sv
module lt_seq_div import lt_eval_pkg::*; #(
   parameter int W = 42
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] num,
   input  logic [W-1:0] den,
   output logic         done,
   output logic [W-1:0] quo
);

   localparam int CW = lt_bits(W + 1);

   logic [W-1:0]  rem_q, q_q, dv_q;
   logic [CW-1:0] cnt_q;
   logic          run_q;
   logic [W:0]    sh;

   assign sh  = {rem_q, q_q[W-1]};
   assign quo = q_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q <= '0;
         q_q   <= '0;
         dv_q  <= '0;
         cnt_q <= '0;
         run_q <= 1'b0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            q_q   <= num;
            dv_q  <= den;
            rem_q <= '0;
            cnt_q <= CW'(W);
            run_q <= 1'b1;
         end else if (run_q) begin
            if (sh >= {1'b0, dv_q}) begin
               rem_q <= W'(sh - {1'b0, dv_q});
               q_q   <= {q_q[W-2:0], 1'b1};
            end else begin
               rem_q <= sh[W-1:0];
               q_q   <= {q_q[W-2:0], 1'b0};
            end
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begin
               run_q <= 1'b0;
               done  <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/lt_isqrt.sv
module lt_isqrt import lt_eval_pkg::*; #(
   parameter int W = 42
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [W-1:0]   rad,
   output logic           done,
   output logic [W/2-1:0] root
);

   localparam int HW = W / 2;
   localparam int RW = HW + 3;
   localparam int CW = lt_bits(HW + 1);

   generate
      if (W % 2 != 0) begin : g_bad_w
         $error("lt_isqrt: W must be even");
      end
   endgenerate

   logic [W-1:0]  rad_q;
   logic [RW-1:0] rem_q;
   logic [HW-1:0] root_q;
   logic [CW-1:0] cnt_q;
   logic          run_q;
   logic [RW-1:0] sh, trial;

   assign sh    = {rem_q[RW-3:0], rad_q[W-1:W-2]};
   assign trial = {1'b0, root_q, 2'b01};
   assign root  = root_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rad_q  <= '0;
         rem_q  <= '0;
         root_q <= '0;
         cnt_q  <= '0;
         run_q  <= 1'b0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            rad_q  <= rad;
            rem_q  <= '0;
            root_q <= '0;
            cnt_q  <= CW'(HW);
            run_q  <= 1'b1;
         end else if (run_q) begin
            rad_q <= {rad_q[W-3:0], 2'b00};
            if (sh >= trial) begin
               rem_q  <= sh - trial;
               root_q <= {root_q[HW-2:0], 1'b1};
            end else begin
               rem_q  <= sh;
               root_q <= {root_q[HW-2:0], 1'b0};
            end
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begin
               run_q <= 1'b0;
               done  <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/lt_topo_eval.sv
module lt_topo_eval import lt_eval_pkg::*; #(
   parameter  int ROWS    = 3,
   parameter  int COLS    = 3,
   parameter  int PROWS   = 3,
   parameter  int PCOLS   = 4,
   parameter  int CNT_W   = 8,
   parameter  int RES_W   = 16,
   parameter  int WGT_W   = 9,
   localparam int N_NODES = ROWS * COLS,
   localparam int NI_W    = lt_bits(N_NODES),
   localparam int PR_W    = lt_bits(PROWS),
   localparam int PC_W    = lt_bits(PCOLS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [WGT_W-1:0] w_df,
   input  logic [WGT_W-1:0] w_cf,
   output logic [NI_W-1:0]  map_addr,
   input  logic [PR_W-1:0]  map_prow,
   input  logic [PC_W-1:0]  map_pcol,
   output logic             busy,
   output logic             done,
   output logic [RES_W-1:0] df_q,
   output logic [RES_W-1:0] cf_q,
   output logic [RES_W-1:0] um_q
);

   localparam int LR_W    = lt_bits(ROWS);
   localparam int LC_W    = lt_bits(COLS);
   localparam int L_H     = PROWS * (PCOLS - 1);
   localparam int L_V     = (PROWS - 1) * PCOLS;
   localparam int N_LINKS = L_H + L_V;
   localparam int LI_W    = lt_bits(N_LINKS);
   localparam int LB      = lt_bits(N_LINKS + 1);
   localparam int SW      = LB + CNT_W;
   localparam int QW      = 2 * SW;
   localparam int DIV_W   = 2 * (LB + CNT_W + 8);
   localparam int ROOT_W  = DIV_W / 2;
   localparam int HOP_W   = lt_bits(4 * (PROWS + PCOLS) + 1);
   localparam int UW      = RES_W + WGT_W + 1;
   localparam logic [RES_W-1:0] RES_MAX = '1;

   generate
      if (N_NODES < 2) begin : g_chk_nodes
         $error("lt_topo_eval: logical mesh needs at least two nodes");
      end
      if (PROWS < ROWS || PCOLS < COLS) begin : g_chk_phys
         $error("lt_topo_eval: physical mesh smaller than logical mesh");
      end
      if (N_LINKS < 1) begin : g_chk_links
         $error("lt_topo_eval: physical mesh has no links");
      end
      if (WGT_W < 9 || RES_W < 9 || RES_W >= ROOT_W) begin : g_chk_w
         $error("lt_topo_eval: weight or result width out of range");
      end
   endgenerate

   eval_state_t st;

   logic [NI_W-1:0]  node;
   logic [LR_W-1:0]  li;
   logic [LC_W-1:0]  lj;
   logic [1:0]       dir;
   logic [PR_W-1:0]  self_r, cur_r, dst_r;
   logic [PC_W-1:0]  self_c, cur_c, dst_c;
   logic [HOP_W-1:0] hop;
   logic [2:0]       kcnt;
   logic [DIV_W-1:0] sum_df, var_q;
   logic [LI_W-1:0]  scan;
   logic [SW-1:0]    s_acc;
   logic [QW-1:0]    q_acc;
   logic [RES_W-1:0] cf_r;
   logic [WGT_W-1:0] wdf_r, wcf_r;

   // ---------------- neighbour selection ----------------
   logic            nb_ok;
   logic [NI_W-1:0] nb_idx;

   always_comb begin
      case (dir)
         2'd0: begin
            nb_ok  = int'(li) < ROWS - 1;
            nb_idx = NI_W'(int'(node) + COLS);
         end
         2'd1: begin
            nb_ok  = li != '0;
            nb_idx = NI_W'(int'(node) - COLS);
         end
         2'd2: begin
            nb_ok  = int'(lj) < COLS - 1;
            nb_idx = NI_W'(int'(node) + 1);
         end
         default: begin
            nb_ok  = lj != '0;
            nb_idx = NI_W'(int'(node) - 1);
         end
      endcase
   end

   assign map_addr = (st == S_DIR && nb_ok) ? nb_idx : node;

   // ---------------- route stepping ----------------
   logic            col_move, row_move, col_up, row_up;
   logic [PC_W-1:0] nxt_c;
   logic [PR_W-1:0] nxt_r;
   logic [LI_W-1:0] link_idx;
   logic            link_inc;

   assign col_move = cur_c != dst_c;
   assign row_move = cur_r != dst_r;
   assign col_up   = dst_c > cur_c;
   assign row_up   = dst_r > cur_r;
   assign nxt_c    = col_up ? cur_c + 1'b1 : cur_c - 1'b1;
   assign nxt_r    = row_up ? cur_r + 1'b1 : cur_r - 1'b1;
   assign link_inc = (st == S_ROUTE) && (col_move || row_move);

   always_comb begin
      if (col_move) begin
         link_idx = LI_W'(int'(cur_r) * (PCOLS - 1) + int'(col_up ? cur_c : nxt_c));
      end else begin
         link_idx = LI_W'(L_H + int'(row_up ? cur_r : nxt_r) * PCOLS + int'(cur_c));
      end
   end

   logic [CNT_W-1:0] rd_cnt;

   lt_link_bank #(
      .NUM   (N_LINKS),
      .CNT_W (CNT_W),
      .IDX_W (LI_W)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (st == S_IDLE && start),
      .inc     (link_inc),
      .inc_idx (link_idx),
      .rd_idx  (scan),
      .rd_cnt  (rd_cnt)
   );

   // ---------------- shared divider and root ----------------
   logic             div_start, div_done;
   logic [DIV_W-1:0] div_num, div_den, div_quo;
   logic [DIV_W-1:0] lq, ss, var_num;

   assign lq      = DIV_W'(N_LINKS) * DIV_W'(q_acc);
   assign ss      = DIV_W'(s_acc) * DIV_W'(s_acc);
   assign var_num = (lq - ss) << 16;

   always_comb begin
      div_start = 1'b0;
      div_num   = '0;
      div_den   = '0;
      case (st)
         S_NDIV: begin
            div_start = 1'b1;
            div_num   = DIV_W'(hop) << 8;
            div_den   = DIV_W'(kcnt);
         end
         S_VDIV: begin
            div_start = 1'b1;
            div_num   = var_num;
            div_den   = DIV_W'(N_LINKS * N_LINKS);
         end
         S_DDIV: begin
            div_start = 1'b1;
            div_num   = sum_df;
            div_den   = DIV_W'(N_NODES);
         end
         default: ;
      endcase
   end

   lt_seq_div #(.W(DIV_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .start (div_start),
      .num   (div_num),
      .den   (div_den),
      .done  (div_done),
      .quo   (div_quo)
   );

   logic              sq_done;
   logic [ROOT_W-1:0] sq_root;

   lt_isqrt #(.W(DIV_W)) u_root (
      .clk   (clk),
      .rst_n (rst_n),
      .start (st == S_ROOT),
      .rad   (var_q),
      .done  (sq_done),
      .root  (sq_root)
   );

   // ---------------- result shaping ----------------
   logic [RES_W-1:0] df_v, cf_v, um_v;
   logic [UW-1:0]    um_full, um_sh;

   assign df_v    = (div_quo > DIV_W'(RES_MAX)) ? RES_MAX : RES_W'(div_quo);
   assign cf_v    = (sq_root > ROOT_W'(RES_MAX)) ? RES_MAX : RES_W'(sq_root);
   assign um_full = UW'(wdf_r) * UW'(df_v) + UW'(wcf_r) * UW'(cf_r);
   assign um_sh   = um_full >> 8;
   assign um_v    = (um_sh > UW'(RES_MAX)) ? RES_MAX : RES_W'(um_sh);

   assign busy = st != S_IDLE;

   // ---------------- sequencer ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         node   <= '0;
         li     <= '0;
         lj     <= '0;
         dir    <= '0;
         self_r <= '0;
         self_c <= '0;
         cur_r  <= '0;
         cur_c  <= '0;
         dst_r  <= '0;
         dst_c  <= '0;
         hop    <= '0;
         kcnt   <= '0;
         sum_df <= '0;
         var_q  <= '0;
         scan   <= '0;
         s_acc  <= '0;
         q_acc  <= '0;
         cf_r   <= '0;
         wdf_r  <= '0;
         wcf_r  <= '0;
         df_q   <= '0;
         cf_q   <= '0;
         um_q   <= '0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            S_IDLE: begin
               if (start) begin
                  wdf_r  <= w_df;
                  wcf_r  <= w_cf;
                  node   <= '0;
                  li     <= '0;
                  lj     <= '0;
                  sum_df <= '0;
                  st     <= S_SELF;
               end
            end
            S_SELF: begin
               self_r <= map_prow;
               self_c <= map_pcol;
               dir    <= '0;
               hop    <= '0;
               kcnt   <= '0;
               st     <= S_DIR;
            end
            S_DIR: begin
               if (nb_ok) begin
                  dst_r <= map_prow;
                  dst_c <= map_pcol;
                  cur_r <= self_r;
                  cur_c <= self_c;
                  kcnt  <= kcnt + 1'b1;
                  st    <= S_ROUTE;
               end else if (dir == 2'd3) begin
                  st <= S_NDIV;
               end else begin
                  dir <= dir + 1'b1;
               end
            end
            S_ROUTE: begin
               if (col_move) begin
                  cur_c <= nxt_c;
                  hop   <= hop + 1'b1;
               end else if (row_move) begin
                  cur_r <= nxt_r;
                  hop   <= hop + 1'b1;
               end else if (dir == 2'd3) begin
                  st <= S_NDIV;
               end else begin
                  dir <= dir + 1'b1;
                  st  <= S_DIR;
               end
            end
            S_NDIV: st <= S_NWAIT;
            S_NWAIT: begin
               if (div_done) begin
                  sum_df <= sum_df + div_quo;
                  if (node == NI_W'(N_NODES - 1)) begin
                     scan  <= '0;
                     s_acc <= '0;
                     q_acc <= '0;
                     st    <= S_SCAN;
                  end else begin
                     node <= node + 1'b1;
                     if (lj == LC_W'(COLS - 1)) begin
                        lj <= '0;
                        li <= li + 1'b1;
                     end else begin
                        lj <= lj + 1'b1;
                     end
                     st <= S_SELF;
                  end
               end
            end
            S_SCAN: begin
               s_acc <= s_acc + SW'(rd_cnt);
               q_acc <= q_acc + QW'(rd_cnt) * QW'(rd_cnt);
               if (scan == LI_W'(N_LINKS - 1)) begin
                  st <= S_VDIV;
               end else begin
                  scan <= scan + 1'b1;
               end
            end
            S_VDIV: st <= S_VWAIT;
            S_VWAIT: begin
               if (div_done) begin
                  var_q <= div_quo;
                  st    <= S_ROOT;
               end
            end
            S_ROOT: st <= S_RWAIT;
            S_RWAIT: begin
               if (sq_done) begin
                  cf_r <= cf_v;
                  st   <= S_DDIV;
               end
            end
            S_DDIV: st <= S_DWAIT;
            S_DWAIT: begin
               if (div_done) begin
                  df_q <= df_v;
                  cf_q <= cf_r;
                  um_q <= um_v;
                  done <= 1'b1;
                  st   <= S_IDLE;
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/lt_topo_eval_chk.sv
module lt_topo_eval_chk #(
   parameter int N_NODES = 9,
   parameter int NI_W    = 4,
   parameter int RES_W   = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic             done,
   input logic [NI_W-1:0]  map_addr,
   input logic [RES_W-1:0] df_q,
   input logic [RES_W-1:0] cf_q,
   input logic [RES_W-1:0] um_q
);

   // R2
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R2
   done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   // R2
   busy_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   // R4
   addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (int'(map_addr) < N_NODES));

   // R12
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(df_q) && $stable(cf_q) && $stable(um_q)));

endmodule

bind lt_topo_eval lt_topo_eval_chk #(
   .N_NODES (N_NODES),
   .NI_W    (NI_W),
   .RES_W   (RES_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .busy     (busy),
   .done     (done),
   .map_addr (map_addr),
   .df_q     (df_q),
   .cf_q     (cf_q),
   .um_q     (um_q)
);

// File: tb/tb_lt_topo_eval.sv
`timescale 1ns/1ps
module tb_lt_topo_eval;

   localparam int LROWS = 3;
   localparam int LCOLS = 3;
   localparam int NN    = LROWS * LCOLS;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       start_sq = 1'b0;
   logic [8:0] w_df = '0;
   logic [8:0] w_cf = '0;
   logic [3:0] map_addr, map_addr_sq;
   logic [1:0] map_prow, map_pcol, prow_sq, pcol_sq;
   logic       busy, done, busy_sq, done_sq;
   logic [15:0] df_q, cf_q, um_q, df_sq, cf_sq, um_sq;

   int mr [0:NN-1];
   int mc [0:NN-1];

   int checks = 0;
   int failures = 0;
   int addr_bad = 0;
   int got_df, got_cf, got_um;

   always #10 clk = ~clk;

   assign map_prow = 2'(mr[map_addr]);
   assign map_pcol = 2'(mc[map_addr]);
   assign prow_sq  = 2'(mr[map_addr_sq]);
   assign pcol_sq  = 2'(mc[map_addr_sq]);

   lt_topo_eval #(.ROWS(3), .COLS(3), .PROWS(3), .PCOLS(4)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .w_df(w_df), .w_cf(w_cf),
      .map_addr(map_addr), .map_prow(map_prow), .map_pcol(map_pcol),
      .busy(busy), .done(done), .df_q(df_q), .cf_q(cf_q), .um_q(um_q));

   lt_topo_eval #(.ROWS(3), .COLS(3), .PROWS(3), .PCOLS(3)) dut_sq (
      .clk(clk), .rst_n(rst_n), .start(start_sq), .w_df(w_df), .w_cf(w_cf),
      .map_addr(map_addr_sq), .map_prow(prow_sq), .map_pcol(pcol_sq),
      .busy(busy_sq), .done(done_sq), .df_q(df_sq), .cf_q(cf_sq), .um_q(um_sq));

   // R4 monitor: address must stay inside the logical node range
   always @(negedge clk) if (busy && int'(map_addr) >= NN) addr_bad++;

   task automatic chk(input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   // independent score model, written from the requirements
   task automatic model(input int pr, input int pc, input int wdf, input int wcf,
                        output int edf, output int ecf, output int eum);
      int lc [0:63];
      int lh, nl;
      longint sdf, s, q, v, rt, um;
      lh = pr * (pc - 1);
      nl = lh + (pr - 1) * pc;
      for (int x = 0; x < 64; x++) lc[x] = 0;
      sdf = 0;
      for (int n = 0; n < NN; n++) begin
         int h, k;
         h = 0; k = 0;
         for (int d = 0; d < 4; d++) begin
            int i, j, ni, nj;
            i = n / LCOLS; j = n % LCOLS;
            ni = i + (d == 0) - (d == 1);
            nj = j + (d == 2) - (d == 3);
            if (ni >= 0 && ni < LROWS && nj >= 0 && nj < LCOLS) begin
               int r, c, dr, dc;
               k++;
               r = mr[n]; c = mc[n];
               dr = mr[ni * LCOLS + nj]; dc = mc[ni * LCOLS + nj];
               while (c != dc) begin   // R7 column direction first
                  if (dc > c) begin lc[r * (pc - 1) + c]++; c++; end
                  else begin lc[r * (pc - 1) + c - 1]++; c--; end
                  h++;
               end
               while (r != dr) begin
                  if (dr > r) begin lc[lh + r * pc + c]++; r++; end
                  else begin lc[lh + (r - 1) * pc + c]++; r--; end
                  h++;
               end
            end
         end
         sdf += (longint'(h) * 256) / k;
      end
      edf = int'(sdf / NN);
      if (edf > 65535) edf = 65535;
      s = 0; q = 0;
      for (int x = 0; x < nl; x++) begin s += lc[x]; q += lc[x] * lc[x]; end
      v = ((nl * q - s * s) << 16) / (nl * nl);
      rt = 0;
      for (int b = 24; b >= 0; b--) begin
         longint t;
         t = rt | (longint'(1) << b);
         if (t * t <= v) rt = t;
      end
      ecf = (rt > 65535) ? 65535 : int'(rt);
      um = (longint'(wdf) * edf + longint'(wcf) * ecf) >> 8;
      eum = (um > 65535) ? 65535 : int'(um);
   endtask

   task automatic set_identity();
      for (int n = 0; n < NN; n++) begin mr[n] = n / LCOLS; mc[n] = n % LCOLS; end
   endtask

   task automatic kick(input int wdf, input int wcf);
      @(negedge clk);
      w_df = 9'(wdf); w_cf = 9'(wcf); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R2 busy after start", busy, 1);
   endtask

   task automatic wait_done();
      int n;
      n = 0;
      while (!done && n < 5000) begin @(negedge clk); n++; end
      chk("R2 done seen", done, 1);
      chk("R2 busy low with done", busy, 0);
      got_df = int'(df_q); got_cf = int'(cf_q); got_um = int'(um_q);
      @(negedge clk);
      chk("R2 done one cycle", done, 0);
   endtask

   task automatic run_and_compare(input string tag, input int wdf, input int wcf);
      int edf, ecf, eum;
      model(3, 4, wdf, wcf, edf, ecf, eum);
      kick(wdf, wcf);
      wait_done();
      chk({tag, " R5 df"}, got_df, edf);
      chk({tag, " R7 R8 cf"}, got_cf, ecf);
      chk({tag, " R10 um"}, got_um, eum);
   endtask

   task automatic t_reset();
      chk("R1 busy", busy, 0);
      chk("R1 done", done, 0);
      chk("R1 df", df_q, 0);
      chk("R1 cf", cf_q, 0);
      chk("R1 um", um_q, 0);
   endtask

   task automatic t_identity();
      set_identity();
      run_and_compare("identity", 128, 128);
      chk("R6 ideal df", got_df, 256);
   endtask

   task automatic t_square_ref();
      int n;
      set_identity();
      @(negedge clk); start_sq = 1'b1;
      @(negedge clk); start_sq = 1'b0;
      n = 0;
      while (!done_sq && n < 5000) begin @(negedge clk); n++; end
      chk("R9 square done", done_sq, 1);
      chk("R9 square cf zero", cf_sq, 0);
      chk("R6 square df", df_sq, 256);
   endtask

   task automatic t_ripple();
      set_identity();
      mc[4] = 2; mc[5] = 3;
      run_and_compare("ripple", 179, 77);
   endtask

   task automatic t_steal();
      mr[0] = 0; mc[0] = 0; mr[1] = 0; mc[1] = 2; mr[2] = 0; mc[2] = 3;
      mr[3] = 2; mc[3] = 0; mr[4] = 1; mc[4] = 1; mr[5] = 1; mc[5] = 3;
      mr[6] = 2; mc[6] = 1; mr[7] = 2; mc[7] = 2; mr[8] = 2; mc[8] = 3;
      run_and_compare("steal", 128, 128);
   endtask

   task automatic t_scramble();
      mr[0] = 2; mc[0] = 3; mr[1] = 0; mc[1] = 0; mr[2] = 1; mc[2] = 2;
      mr[3] = 0; mc[3] = 3; mr[4] = 2; mc[4] = 0; mr[5] = 1; mc[5] = 1;
      mr[6] = 0; mc[6] = 1; mr[7] = 2; mc[7] = 2; mr[8] = 1; mc[8] = 3;
      run_and_compare("scramble", 200, 56);
   endtask

   task automatic t_weights();
      run_and_compare("wdf only", 256, 0);
      chk("R10 um equals df", got_um, got_df);
      run_and_compare("wcf only", 0, 256);
      chk("R10 um equals cf", got_um, got_cf);
   endtask

   task automatic t_rerun();
      int df1, cf1;
      run_and_compare("rerun a", 128, 128);
      df1 = got_df; cf1 = got_cf;
      run_and_compare("rerun b", 128, 128);
      chk("R11 rerun df", got_df, df1);
      chk("R11 rerun cf", got_cf, cf1);
   endtask

   task automatic t_start_busy();
      int edf, ecf, eum, extra;
      model(3, 4, 256, 0, edf, ecf, eum);
      kick(256, 0);
      repeat (20) @(negedge clk);
      w_df = 9'd0; w_cf = 9'd256; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      chk("R3 um keeps first weights", got_um, edf);
      chk("R3 df", got_df, edf);
      extra = 0;
      repeat (1500) begin @(negedge clk); if (done || busy) extra++; end
      chk("R3 no second run", extra, 0);
   endtask

   task automatic t_hold();
      int df0, cf0, um0;
      df0 = int'(df_q); cf0 = int'(cf_q); um0 = int'(um_q);
      mc[0] = 3; mr[0] = 2;
      w_df = 9'd17; w_cf = 9'd3;
      repeat (50) @(negedge clk);
      chk("R12 df held", df_q, df0);
      chk("R12 cf held", cf_q, cf0);
      chk("R12 um held", um_q, um0);
   endtask

   initial begin
      set_identity();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_identity();
      t_square_ref();
      t_ripple();
      t_steal();
      t_scramble();
      t_weights();
      t_rerun();
      t_start_busy();
      t_hold();
      chk("R4 address range", addr_bad, 0);
      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

endmodule